// File: doc/BRIEF.md
# PLL Reconfiguration Bypass Sequencer

This block moves a PLL to a new VCO setting without letting downstream logic see an unlocked clock. The setting is modelled as an integer multiplier, `mult_o`, that the block drives straight into the PLL. A caller raises `req_i` for one cycle with a new `target_i`. The sequencer then takes one of two paths.

The bypass path is the safe default. It first switches every PLL-derived clock over to the reference oscillator by raising `bypass_o`. One cycle later it writes the new multiplier. It then watches the synchronised lock status and lowers `bypass_o` only once lock is reported. If lock does not return within a programmable number of cycles, it gives up and raises `error_o`. In that case the clocks stay on the reference.

The ramp path is used when the PLL is already running from its VCO and the caller asks for it. This path never bypasses. It walks the multiplier toward the target in steps of at most one fifth of the present value, which is small enough to keep lock, and it waits a programmable settle time after each step.

Top module: `pll_bypass_seq`

## Requirements
- R1: After reset `mult_o` equals RESET_MULT (default 100), and `bypass_o`, `busy_o`, `done_o` and `error_o` are all 0.
- R2: On the bypass path, `bypass_o` is 1 in the first cycle after a request is accepted while `mult_o` still holds its old value. `mult_o` takes the target one cycle later. The multiplier never changes in a cycle where `bypass_o` has just risen.
- R3: `bypass_o` is lowered only while lock is reported. Lock is seen through a synchroniser of SYNC_STAGES (default 2) flip-flops and is disregarded during the first SYNC_STAGES+3 cycles after the new multiplier is written.
- R4: If lock is not seen within `timeout_i` cycles of the write, `error_o` becomes 1, `bypass_o` stays 1, `busy_o` falls and `done_o` does not pulse. `error_o` clears when the next request is accepted.
- R5: The ramp path is taken only when all four of these hold: `ramp_en_i` is 1, `bypass_o` is 0, the target is at least STEP_DIV (default 5), and the current multiplier is at least STEP_DIV. In every other case the bypass path is taken, and on the ramp path `bypass_o` stays 0 throughout.
- R6: Each ramp step moves `mult_o` from c to min(target, c + floor(c/5)) when rising, or to max(target, c − floor(c/5)) when falling.
- R7: On the ramp path, consecutive changes of `mult_o` are exactly `settle_i`+1 cycles apart. `done_o` pulses `settle_i`+1 cycles after the step that reaches the target.
- R8: A request raised while `busy_o` is 1 is ignored: it neither changes the target in progress nor starts another sequence.
- R9: `done_o` is a single-cycle pulse, issued only when a sequence completes successfully. `busy_o` is 0 in the cycle of the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request pulse, accepted when idle |
| target_i | input | MUL_W | Requested multiplier |
| ramp_en_i | input | 1 | Prefer stepped change without bypass |
| settle_i | input | SET_W | Cycles to hold after each ramp step, minus one |
| timeout_i | input | TMO_W | Lock wait limit in cycles |
| lock_i | input | 1 | Asynchronous lock status from the PLL |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Successful completion pulse |
| error_o | output | 1 | Lock wait expired |
| bypass_o | output | 1 | PLL outputs driven from reference oscillator |
| mult_o | output | MUL_W | Multiplier applied to the PLL |

## Verification
The assertions assume that the PLL drops lock only after a multiplier write made under bypass. They also assume that lock never glitches low while the VCO is running on bounded ramp steps, and that each target fits in MUL_W bits. The bench's PLL model holds to these assumptions. It lowers `lock_i` one cycle after seeing a bypassed write, restores it after a chosen delay (or never, for the timeout case), and leaves lock steady throughout ramps. Requests are raised at the falling edge for exactly one cycle, and stray requests are issued only while the block reports busy.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_BYP,
      ST_LOCK,
      ST_STEP,
      ST_SETTLE
   } seq_state_e;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pll_lock_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pll_ramp_step.sv
module pll_ramp_step #(
   parameter int MUL_W    = 12,
   parameter int STEP_DIV = 5
) (
   input  logic [MUL_W-1:0] cur_i,
   input  logic [MUL_W-1:0] tgt_i,
   output logic [MUL_W-1:0] nxt_o
);
   localparam bit IS_POW2 = ((STEP_DIV & (STEP_DIV - 1)) == 0);

   if (STEP_DIV < 2) begin : g_bad_div
      $error("pll_ramp_step: STEP_DIV must be at least 2");
   end

   logic [MUL_W-1:0] frac;

   if (IS_POW2) begin : g_shift
      localparam int SH = $clog2(STEP_DIV);
      assign frac = cur_i >> SH;
   end else begin : g_div
      assign frac = cur_i / MUL_W'(STEP_DIV);
   end

   logic [MUL_W:0]   up_lim;
   logic [MUL_W-1:0] dn_lim;

   assign up_lim = {1'b0, cur_i} + {1'b0, frac};
   assign dn_lim = cur_i - frac;

   always_comb begin
      if (tgt_i > cur_i) begin
         nxt_o = ({1'b0, tgt_i} < up_lim) ? tgt_i : up_lim[MUL_W-1:0];
      end else if (tgt_i < cur_i) begin
         nxt_o = (tgt_i > dn_lim) ? tgt_i : dn_lim;
      end else begin
         nxt_o = cur_i;
      end
   end
endmodule

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (clr_i)                  cnt_q <= '0;
      else if (inc_i && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/pll_bypass_seq.sv
module pll_bypass_seq #(
   parameter int MUL_W       = 12,
   parameter int TMO_W       = 16,
   parameter int SET_W       = 12,
   parameter int SYNC_STAGES = 2,
   parameter int STEP_DIV    = 5,
   parameter int RESET_MULT  = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [MUL_W-1:0] target_i,
   input  logic             ramp_en_i,
   input  logic [SET_W-1:0] settle_i,
   input  logic [TMO_W-1:0] timeout_i,
   input  logic             lock_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             error_o,
   output logic             bypass_o,
   output logic [MUL_W-1:0] mult_o
);
   import pll_seq_pkg::*;

   localparam int CNT_W      = (TMO_W > SET_W) ? TMO_W : SET_W;
   localparam int GUARD      = SYNC_STAGES + 3;
   localparam int RAMP_FLOOR = STEP_DIV;

   if (MUL_W < 4) begin : g_bad_mul_w
      $error("pll_bypass_seq: MUL_W must be at least 4");
   end
   if (RESET_MULT >= (1 << MUL_W) || RESET_MULT < 1) begin : g_bad_reset
      $error("pll_bypass_seq: RESET_MULT must fit in MUL_W bits");
   end
   if (CNT_W < 4 || GUARD >= (1 << CNT_W)) begin : g_bad_cnt
      $error("pll_bypass_seq: counter too narrow for lock guard");
   end

   seq_state_e       state_q;
   logic [MUL_W-1:0] tgt_q;
   logic [MUL_W-1:0] mult_q;
   logic [SET_W-1:0] settle_q;
   logic [TMO_W-1:0] tmo_q;
   logic             byp_q;
   logic             busy_q;
   logic             done_q;
   logic             err_q;

   logic             lock_s;
   logic [MUL_W-1:0] step_nxt;
   logic [CNT_W-1:0] wait_cnt;
   logic             cnt_clr;
   logic             cnt_inc;
   logic             lock_ok;
   logic             tmo_hit;
   logic             settle_hit;
   logic             ramp_ok;

   pll_lock_sync #(
      .STAGES (SYNC_STAGES)
   ) u_lock_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (lock_i),
      .sync_o  (lock_s)
   );

   pll_ramp_step #(
      .MUL_W    (MUL_W),
      .STEP_DIV (STEP_DIV)
   ) u_step (
      .cur_i (mult_q),
      .tgt_i (tgt_q),
      .nxt_o (step_nxt)
   );

   pll_wait_timer #(
      .W (CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cnt_clr),
      .inc_i (cnt_inc),
      .cnt_o (wait_cnt)
   );

   assign lock_ok    = lock_s && (wait_cnt >= CNT_W'(GUARD));
   assign tmo_hit    = wait_cnt >= CNT_W'(tmo_q);
   assign settle_hit = wait_cnt >= CNT_W'(settle_q);
   assign ramp_ok    = ramp_en_i && !byp_q
                       && (target_i >= MUL_W'(RAMP_FLOOR))
                       && (mult_q >= MUL_W'(RAMP_FLOOR));

   always_comb begin
      cnt_clr = 1'b0;
      cnt_inc = 1'b0;
      unique case (state_q)
         ST_LOCK:   cnt_inc = !(lock_ok || tmo_hit);
         ST_SETTLE: begin
            if (settle_hit) cnt_clr = 1'b1;
            else            cnt_inc = 1'b1;
         end
         default:   cnt_clr = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         tgt_q    <= MUL_W'(RESET_MULT);
         mult_q   <= MUL_W'(RESET_MULT);
         settle_q <= '0;
         tmo_q    <= '0;
         byp_q    <= 1'b0;
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_i) begin
                  tgt_q    <= target_i;
                  settle_q <= settle_i;
                  tmo_q    <= timeout_i;
                  err_q    <= 1'b0;
                  busy_q   <= 1'b1;
                  if (ramp_ok) begin
                     state_q <= ST_STEP;
                  end else begin
                     byp_q   <= 1'b1;
                     state_q <= ST_BYP;
                  end
               end
            end
            ST_BYP: begin
               mult_q  <= tgt_q;
               state_q <= ST_LOCK;
            end
            ST_LOCK: begin
               if (lock_ok) begin
                  byp_q   <= 1'b0;
                  done_q  <= 1'b1;
                  busy_q  <= 1'b0;
                  state_q <= ST_IDLE;
               end else if (tmo_hit) begin
                  err_q   <= 1'b1;
                  busy_q  <= 1'b0;
                  state_q <= ST_IDLE;
               end
            end
            ST_STEP: begin
               mult_q  <= step_nxt;
               state_q <= ST_SETTLE;
            end
            ST_SETTLE: begin
               if (settle_hit) begin
                  if (mult_q == tgt_q) begin
                     done_q  <= 1'b1;
                     busy_q  <= 1'b0;
                     state_q <= ST_IDLE;
                  end else begin
                     mult_q <= step_nxt;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o   = busy_q;
   assign done_o   = done_q;
   assign error_o  = err_q;
   assign bypass_o = byp_q;
   assign mult_o   = mult_q;
endmodule

// File: rtl/pll_bypass_seq_chk.sv
module pll_bypass_seq_chk #(
   parameter int MUL_W    = 12,
   parameter int STEP_DIV = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy_o,
   input logic             done_o,
   input logic             error_o,
   input logic             bypass_o,
   input logic             lock_s,
   input logic [MUL_W-1:0] mult_o
);
   localparam int WW = MUL_W + 8;

   logic [MUL_W-1:0] prev_mult;
   logic             prev_byp;
   logic [MUL_W-1:0] dlt;
   logic [WW-1:0]    scaled;

   always_ff @(posedge clk) begin
      prev_mult <= mult_o;
      prev_byp  <= bypass_o;
   end

   assign dlt    = (mult_o > prev_mult) ? (mult_o - prev_mult) : (prev_mult - mult_o);
   assign scaled = WW'(dlt) * WW'(STEP_DIV);

   AST_APPLY_AFTER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      ((mult_o != prev_mult) && bypass_o) |-> prev_byp); // R2

   AST_RELEASE_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bypass_o) |-> $past(lock_s)); // R3

   AST_ERROR_KEEPS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error_o) |-> (bypass_o && !busy_o && !done_o)); // R4

   AST_RAMP_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ((mult_o != prev_mult) && !bypass_o) |-> (scaled <= WW'(prev_mult))); // R6

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !error_o)); // R9
endmodule

bind pll_bypass_seq pll_bypass_seq_chk #(
   .MUL_W    (MUL_W),
   .STEP_DIV (STEP_DIV)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .error_o  (error_o),
   .bypass_o (bypass_o),
   .lock_s   (lock_s),
   .mult_o   (mult_o)
);

// File: tb/test_pll_bypass_seq.sv
module test_pll_bypass_seq;
   localparam int MUL_W = 12;
   localparam int TMO_W = 16;
   localparam int SET_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_i = 1'b0;
   logic [MUL_W-1:0] target_i = '0;
   logic             ramp_en_i = 1'b0;
   logic [SET_W-1:0] settle_i = '0;
   logic [TMO_W-1:0] timeout_i = '0;
   logic             lock_i;
   logic             busy_o, done_o, error_o, bypass_o;
   logic [MUL_W-1:0] mult_o;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   pll_bypass_seq i_pll_bypass_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req_i),
      .target_i  (target_i),
      .ramp_en_i (ramp_en_i),
      .settle_i  (settle_i),
      .timeout_i (timeout_i),
      .lock_i    (lock_i),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .error_o   (error_o),
      .bypass_o  (bypass_o),
      .mult_o    (mult_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // PLL model: loses lock after a write made under bypass, regains it later
   int lock_delay = 6;
   bit never_lock = 1'b0;
   int lcnt = 0;
   logic [MUL_W-1:0] m_prev = 12'd100;

   always @(posedge clk) begin
      if (!rst_n) begin
         lock_i <= 1'b1;
         lcnt   <= 0;
         m_prev <= 12'd100;
      end else begin
         m_prev <= mult_o;
         if (mult_o != m_prev && bypass_o) begin
            lock_i <= 1'b0;
            lcnt   <= lock_delay;
         end else if (lcnt > 0) begin
            lcnt <= lcnt - 1;
         end else if (!never_lock) begin
            lock_i <= 1'b1;
         end
      end
   end

   function automatic int exp_step(input int cur, input int tgt);
      int lim;
      if (tgt > cur) begin
         lim = cur + cur / 5;
         return (tgt < lim) ? tgt : lim;
      end else if (tgt < cur) begin
         lim = cur - cur / 5;
         return (tgt > lim) ? tgt : lim;
      end
      return cur;
   endfunction

   // Monitor, sampled at the falling edge
   int cyc = 0;
   int last_step = -1;
   int exp_settle = 0;
   int ramp_tgt = 0;
   bit ramp_expect = 1'b0;
   bit byp_seen = 1'b0;
   int done_cnt = 0;
   int mon_prev_mult = 100;
   bit mon_prev_byp = 1'b0;
   bit mon_prev_done = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (bypass_o) byp_seen = 1'b1;
         if (int'(mult_o) != mon_prev_mult) begin
            if (bypass_o) begin
               chk("R2 bypass held before write", int'(mon_prev_byp), 1);
            end else begin
               chk("R6 ramp step value", int'(mult_o), exp_step(mon_prev_mult, ramp_tgt));
               if (last_step >= 0) chk("R7 step spacing", cyc - last_step, exp_settle + 1);
               last_step = cyc;
            end
         end
         if (!bypass_o && mon_prev_byp) chk("R3 lock high at release", int'(lock_i), 1);
         if (done_o) begin
            done_cnt++;
            chk("R9 busy low with done", int'(busy_o), 0);
            if (ramp_expect) chk("R7 done after final step", cyc - last_step, exp_settle + 1);
         end
         if (mon_prev_done) chk("R9 done lasts one cycle", int'(done_o), 0);
         mon_prev_mult = int'(mult_o);
         mon_prev_byp  = bypass_o;
         mon_prev_done = done_o;
      end
   end

   task automatic send(input int tgt, input bit ramp, input int settle, input int tmo);
      @(negedge clk);
      req_i     = 1'b1;
      target_i  = MUL_W'(tgt);
      ramp_en_i = ramp;
      settle_i  = SET_W'(settle);
      timeout_i = TMO_W'(tmo);
      @(negedge clk);
      req_i = 1'b0;
   endtask

   task automatic wait_idle(input string tag);
      int n = 0;
      while (busy_o && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk(tag, int'(busy_o), 0);
   endtask

   task automatic t_reset;
      chk("R1 reset mult", int'(mult_o), 100);
      chk("R1 reset bypass", int'(bypass_o), 0);
      chk("R1 reset busy", int'(busy_o), 0);
      chk("R1 reset done", int'(done_o), 0);
      chk("R1 reset error", int'(error_o), 0);
   endtask

   task automatic t_bypass(input int tgt);
      int old = int'(mult_o);
      int d0 = done_cnt;
      ramp_expect = 1'b0;
      send(tgt, 1'b0, 0, 200);
      chk("R2 bypass raised after accept", int'(bypass_o), 1);
      chk("R2 mult unchanged first cycle", int'(mult_o), old);
      @(negedge clk);
      chk("R2 mult written next cycle", int'(mult_o), tgt);
      wait_idle("R3 bypass sequence completes");
      @(negedge clk);
      chk("R3 bypass released", int'(bypass_o), 0);
      chk("R9 one done per sequence", done_cnt - d0, 1);
      chk("R4 no error on success", int'(error_o), 0);
   endtask

   task automatic t_timeout;
      int d0 = done_cnt;
      ramp_expect = 1'b0;
      never_lock  = 1'b1;
      send(300, 1'b0, 0, 20);
      wait_idle("R4 timeout ends sequence");
      @(negedge clk);
      chk("R4 error raised", int'(error_o), 1);
      chk("R4 bypass kept", int'(bypass_o), 1);
      chk("R4 mult written", int'(mult_o), 300);
      chk("R4 no done on timeout", done_cnt - d0, 0);
      never_lock = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic t_forced_bypass;
      ramp_expect = 1'b0;
      send(320, 1'b1, 0, 200);
      chk("R4 error cleared on accept", int'(error_o), 0);
      chk("R5 bypass path when already bypassed", int'(bypass_o), 1);
      @(negedge clk);
      chk("R5 forced bypass write", int'(mult_o), 320);
      wait_idle("R5 forced bypass completes");
      @(negedge clk);
      chk("R5 bypass released", int'(bypass_o), 0);
   endtask

   task automatic t_ramp(input int tgt, input int settle, input int stray);
      int d0 = done_cnt;
      ramp_tgt    = tgt;
      exp_settle  = settle;
      last_step   = -1;
      ramp_expect = 1'b1;
      byp_seen    = 1'b0;
      send(tgt, 1'b1, settle, 200);
      chk("R5 ramp keeps bypass low", int'(bypass_o), 0);
      if (stray >= 0) begin
         repeat (2) @(negedge clk);
         req_i    = 1'b1;
         target_i = MUL_W'(stray);
         @(negedge clk);
         req_i = 1'b0;
      end
      wait_idle("R7 ramp completes");
      repeat (3) @(negedge clk);
      chk("R6 ramp reaches target", int'(mult_o), tgt);
      chk("R5 no bypass during ramp", int'(byp_seen), 0);
      chk("R8 single done for ramp", done_cnt - d0, 1);
      chk("R8 no restart after ramp", int'(busy_o), 0);
      ramp_expect = 1'b0;
   endtask

   task automatic t_small(input int tgt);
      ramp_expect = 1'b0;
      send(tgt, 1'b1, 0, 200);
      chk("R5 small value forces bypass", int'(bypass_o), 1);
      wait_idle("R5 small value sequence completes");
      @(negedge clk);
      chk("R5 small value written", int'(mult_o), tgt);
   endtask

   task automatic t_busy_ignore;
      int d0 = done_cnt;
      ramp_expect = 1'b0;
      send(150, 1'b0, 0, 200);
      repeat (2) @(negedge clk);
      req_i     = 1'b1;
      target_i  = 12'd999;
      ramp_en_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      wait_idle("R8 sequence completes");
      repeat (4) @(negedge clk);
      chk("R8 stray request ignored", int'(mult_o), 150);
      chk("R8 no second sequence", int'(busy_o), 0);
      chk("R8 one done only", done_cnt - d0, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL all watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bypass(250);
      t_timeout();
      t_forced_bypass();
      t_ramp(100, 3, -1);
      t_ramp(200, 0, -1);
      t_ramp(300, 4, 50);
      t_small(3);
      t_small(100);
      t_busy_ignore();
      repeat (5) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule